// File: doc/BRIEF.md
# Bridge Error Capture and Reporting Unit

This unit sits beside a memory/IO bridge and gathers the error events that the bridge's bus, memory and ECC logic detect. Each event arrives as a one-cycle pulse on its own class line, together with a shared set of attributes: address, command code, ECC syndrome, PCI window number and a DMA/CPU source flag. The unit keeps a sticky status bit for each of twelve error classes. It also raises a level correctable-error interrupt and a level machine-check output, each gated by a per-class mask.

The details of the first error are frozen in a group of capture registers. The captured fields are the address, split into a high part and a 16-byte-aligned low part, the command, the syndrome, the window, the source flag and the index of the captured class. These registers stay locked until software clears the status. If a class fires again while its status bit is still set, a per-class lost flag records it, and the captured details are left unchanged.

Software reaches the unit through a flat register port. Writes take effect on the clock edge; reads are combinational. Status, lost and valid bits are cleared by writing ones to them.

Top module: `errcap_top`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets status bit i, readable at register 0 bits [11:0], one cycle later. The class indices are: 0 correctable ECC, 1 uncorrectable ECC, 2 CPU bus parity, 3 nonexistent memory, 4 PCI SERR, 5 PCI data parity, 6 PCI address parity, 7 received master abort, 8 received target abort, 9 invalid scatter/gather PTE, 10 illegal flash write, 11 I/O timeout. Register 0 bit 31 is the valid bit, and it is set whenever any status bit is set.
- R2: When an event arrives while nothing is locked, the capture registers take its details. Register 3 holds address bits [31:4] at bits [31:4], with bits [3:0] reading 0. Register 4 holds address bits [34:32] at [2:0], the command at [11:8] and the source flag at bit 16. Register 5 holds the syndrome at [7:0], the window at [9:8] and the captured class index at [15:12].
- R3: While the valid bit is set, the capture registers do not change. A write to register 0 that clears valid unlocks them, and the next event is captured again.
- R4: Lost bits sit at register 0 bit 16+i. Lost bit i sets when class i fires while status bit i is already set. The SERR class (index 4) has no lost bit, and bit 20 always reads 0.
- R5: Status, lost and valid bits clear when a 1 is written to them; writing 0 leaves a bit unchanged. Valid clears only if bit 31 is written as 1 and no status bit remains set after the write. Otherwise valid stays set and the capture stays locked.
- R6: When several events arrive in the same unlocked cycle, all their status bits set, but only one is captured. The priority is uncorrectable ECC, then CPU parity, then nonexistent memory, then the PCI classes in index order 4 to 11, and correctable ECC last.
- R7: Register 1 bits [11:0] are the read/write mask. `err_irq` is a level equal to status[0] AND mask[0]. `err_mchk` is a level equal to the OR of status AND mask over classes 1 to 11.
- R8: Register 2 bit 0 enables PCI address-parity detection and bit 1 enables PCI data-parity detection. While an enable bit is 0, events of that class are ignored entirely.
- R9: The captured source flag (register 4 bit 16) equals `evt_dma` only when the captured class is nonexistent memory; for every other captured class it reads 0.
- R10: After reset, status, lost, valid and mask read 0, register 2 reads 3, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Write strobe for the register at `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_pulse | input | 12 | One-cycle error event per class |
| evt_line | input | ADDR_W-4 | Error address bits [ADDR_W-1:4] |
| evt_cmd | input | CMD_W | Command code of the failing transaction |
| evt_syn | input | SYN_W | ECC syndrome |
| evt_win | input | WIN_W | PCI window number |
| evt_dma | input | 1 | 1 when the access came from DMA, 0 when it came from the CPU |
| err_irq | output | 1 | Correctable-error interrupt level |
| err_mchk | output | 1 | Machine-check level for the uncorrectable classes |

## Verification
The bench uses the default widths: a 35-bit address, a 4-bit command, an 8-bit syndrome and a 2-bit window. With these widths every field of the capture registers is populated, including the three top address bits and the upper window bit, so a field shifted or truncated in the read words shows up as a wrong value. These defaults also make it possible to drive a multi-class pulse in which the correctable class and a lower-priority PCI class compete with nonexistent memory. That case exercises both the priority pick and the source-flag qualification in the same capture.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int NCLS      = 12;
  localparam int CLS_W     = 4;
  localparam int LOST_OFS  = 16;
  localparam int VALID_BIT = 31;
  localparam int DATA_W    = 32;

  // class indices (the capture priority depends on them)
  localparam int C_CORR  = 0;
  localparam int C_UNC   = 1;
  localparam int C_CPAR  = 2;
  localparam int C_NXM   = 3;
  localparam int C_SERR  = 4;
  localparam int C_DPAR  = 5;
  localparam int C_APAR  = 6;

  // register indices
  localparam logic [2:0] RA_STATUS = 3'd0;
  localparam logic [2:0] RA_MASK   = 3'd1;
  localparam logic [2:0] RA_CTRL   = 3'd2;
  localparam logic [2:0] RA_ADLO   = 3'd3;
  localparam logic [2:0] RA_ADHI   = 3'd4;
  localparam logic [2:0] RA_SYN    = 3'd5;

  typedef logic [NCLS-1:0] cls_vec_t;

  localparam cls_vec_t LOSTABLE  = ~(cls_vec_t'(1) << C_SERR);
  localparam cls_vec_t CORR_GRP  = cls_vec_t'(1) << C_CORR;
  localparam cls_vec_t UNC_GRP   = ~CORR_GRP;

  // lowest index among classes 1..NCLS-1 wins; correctable only if alone
  function automatic logic [CLS_W-1:0] pick_first(input cls_vec_t v);
    logic [CLS_W-1:0] r;
    r = CLS_W'(C_CORR);
    for (int i = NCLS-1; i >= 1; i--) begin
      if (v[i]) r = CLS_W'(i);
    end
    return r;
  endfunction

  function automatic logic group_hit(input cls_vec_t st, input cls_vec_t mk,
                                     input cls_vec_t grp);
    return |(st & mk & grp);
  endfunction
endpackage

// File: rtl/errcap_status.sv
module errcap_status
  import errcap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cls_vec_t evt,
  input  logic     status_wr,
  input  cls_vec_t clr_bits,
  input  cls_vec_t clr_lost,
  input  logic     clr_valid,
  output cls_vec_t status_q,
  output cls_vec_t lost_q,
  output logic     valid_q,
  output logic     cap_open,
  output logic     cap_fire
);
  cls_vec_t status_kept, lost_kept;
  logic     unlock;

  always_comb begin
    status_kept = status_wr ? (status_q & ~clr_bits) : status_q;
    lost_kept   = status_wr ? (lost_q & ~clr_lost) : lost_q;
    unlock      = status_wr && clr_valid && (status_kept == '0);
    cap_open    = !valid_q || unlock;
    cap_fire    = cap_open && (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      lost_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      status_q <= status_kept | evt;
      lost_q   <= lost_kept | (evt & status_kept & LOSTABLE);
      valid_q  <= (valid_q && !unlock) || (|evt);
    end
  end
endmodule

// File: rtl/errcap_capture.sv
module errcap_capture
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 35,
  parameter int CMD_W  = 4,
  parameter int SYN_W  = 8,
  parameter int WIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_fire,
  input  cls_vec_t          evt,
  input  logic [ADDR_W-1:4] evt_line,
  input  logic [CMD_W-1:0]  evt_cmd,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic [WIN_W-1:0]  evt_win,
  input  logic              evt_dma,
  output logic [ADDR_W-1:4] cap_line,
  output logic [CMD_W-1:0]  cap_cmd,
  output logic [SYN_W-1:0]  cap_syn,
  output logic [WIN_W-1:0]  cap_win,
  output logic              cap_dma,
  output logic [CLS_W-1:0]  cap_cls
);
  logic [CLS_W-1:0] win_cls;

  always_comb win_cls = pick_first(evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_line <= '0;
      cap_cmd  <= '0;
      cap_syn  <= '0;
      cap_win  <= '0;
      cap_dma  <= 1'b0;
      cap_cls  <= '0;
    end else if (cap_fire) begin
      cap_line <= evt_line;
      cap_cmd  <= evt_cmd;
      cap_syn  <= evt_syn;
      cap_win  <= evt_win;
      cap_dma  <= evt_dma && (win_cls == CLS_W'(C_NXM));
      cap_cls  <= win_cls;
    end
  end
endmodule

// File: rtl/errcap_report.sv
module errcap_report
  import errcap_pkg::*;
(
  input  cls_vec_t status_q,
  input  cls_vec_t mask_q,
  output logic     err_irq,
  output logic     err_mchk
);
  always_comb begin
    err_irq  = group_hit(status_q, mask_q, CORR_GRP);
    err_mchk = group_hit(status_q, mask_q, UNC_GRP);
  end
endmodule

// File: rtl/errcap_csr.sv
module errcap_csr
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 35,
  parameter int CMD_W  = 4,
  parameter int SYN_W  = 8,
  parameter int WIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  cls_vec_t          status_q,
  input  cls_vec_t          lost_q,
  input  logic              valid_q,
  input  logic [ADDR_W-1:4] cap_line,
  input  logic [CMD_W-1:0]  cap_cmd,
  input  logic [SYN_W-1:0]  cap_syn,
  input  logic [WIN_W-1:0]  cap_win,
  input  logic              cap_dma,
  input  logic [CLS_W-1:0]  cap_cls,
  output logic [DATA_W-1:0] reg_rdata,
  output cls_vec_t          mask_q,
  output logic              apar_en,
  output logic              dpar_en,
  output logic              status_wr,
  output cls_vec_t          clr_bits,
  output cls_vec_t          clr_lost,
  output logic              clr_valid
);
  localparam int HI_W = ADDR_W - 32;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[LOST_OFS-1:NCLS], reg_wdata[VALID_BIT-1:LOST_OFS+NCLS]};

  assign status_wr = reg_wr && (reg_addr == RA_STATUS);
  assign clr_bits  = reg_wdata[NCLS-1:0];
  assign clr_lost  = reg_wdata[LOST_OFS +: NCLS];
  assign clr_valid = reg_wdata[VALID_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      apar_en <= 1'b1;
      dpar_en <= 1'b1;
    end else if (reg_wr) begin
      if (reg_addr == RA_MASK) mask_q <= reg_wdata[NCLS-1:0];
      if (reg_addr == RA_CTRL) begin
        apar_en <= reg_wdata[0];
        dpar_en <= reg_wdata[1];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_STATUS: begin
        reg_rdata[NCLS-1:0]        = status_q;
        reg_rdata[LOST_OFS +: NCLS] = lost_q;
        reg_rdata[VALID_BIT]        = valid_q;
      end
      RA_MASK:  reg_rdata[NCLS-1:0] = mask_q;
      RA_CTRL:  reg_rdata[1:0] = {dpar_en, apar_en};
      RA_ADLO:  reg_rdata[31:4] = cap_line[31:4];
      RA_ADHI: begin
        reg_rdata[HI_W-1:0]  = cap_line[ADDR_W-1:32];
        reg_rdata[8 +: CMD_W] = cap_cmd;
        reg_rdata[16]         = cap_dma;
      end
      RA_SYN: begin
        reg_rdata[SYN_W-1:0]   = cap_syn;
        reg_rdata[8 +: WIN_W]  = cap_win;
        reg_rdata[12 +: CLS_W] = cap_cls;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/errcap_top.sv
module errcap_top
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 35,
  parameter int CMD_W  = 4,
  parameter int SYN_W  = 8,
  parameter int WIN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [11:0]       evt_pulse,
  input  logic [ADDR_W-1:4] evt_line,
  input  logic [CMD_W-1:0]  evt_cmd,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic [WIN_W-1:0]  evt_win,
  input  logic              evt_dma,
  output logic              err_irq,
  output logic              err_mchk
);
  localparam int CAPW = (ADDR_W - 4) + CMD_W + SYN_W + WIN_W + 1 + CLS_W;

  cls_vec_t          evt_gated, status_q, lost_q, mask_q, clr_bits, clr_lost;
  logic              valid_q, cap_open, cap_fire, status_wr, clr_valid;
  logic              apar_en, dpar_en;
  logic [ADDR_W-1:4] cap_line;
  logic [CMD_W-1:0]  cap_cmd;
  logic [SYN_W-1:0]  cap_syn;
  logic [WIN_W-1:0]  cap_win;
  logic              cap_dma;
  logic [CLS_W-1:0]  cap_cls;
  logic [CAPW-1:0]   cap_bus;

  always_comb begin
    evt_gated         = evt_pulse;
    evt_gated[C_APAR] = evt_pulse[C_APAR] && apar_en;
    evt_gated[C_DPAR] = evt_pulse[C_DPAR] && dpar_en;
  end

  assign cap_bus = {cap_line, cap_cmd, cap_syn, cap_win, cap_dma, cap_cls};

  errcap_csr #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .SYN_W(SYN_W), .WIN_W(WIN_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .status_q(status_q), .lost_q(lost_q),
    .valid_q(valid_q), .cap_line(cap_line), .cap_cmd(cap_cmd),
    .cap_syn(cap_syn), .cap_win(cap_win), .cap_dma(cap_dma),
    .cap_cls(cap_cls), .reg_rdata(reg_rdata), .mask_q(mask_q),
    .apar_en(apar_en), .dpar_en(dpar_en), .status_wr(status_wr),
    .clr_bits(clr_bits), .clr_lost(clr_lost), .clr_valid(clr_valid)
  );

  errcap_status u_status (
    .clk(clk), .rst_n(rst_n), .evt(evt_gated), .status_wr(status_wr),
    .clr_bits(clr_bits), .clr_lost(clr_lost), .clr_valid(clr_valid),
    .status_q(status_q), .lost_q(lost_q), .valid_q(valid_q),
    .cap_open(cap_open), .cap_fire(cap_fire)
  );

  errcap_capture #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .SYN_W(SYN_W), .WIN_W(WIN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .evt(evt_gated),
    .evt_line(evt_line), .evt_cmd(evt_cmd), .evt_syn(evt_syn),
    .evt_win(evt_win), .evt_dma(evt_dma), .cap_line(cap_line),
    .cap_cmd(cap_cmd), .cap_syn(cap_syn), .cap_win(cap_win),
    .cap_dma(cap_dma), .cap_cls(cap_cls)
  );

  errcap_report u_rep (
    .status_q(status_q), .mask_q(mask_q), .err_irq(err_irq), .err_mchk(err_mchk)
  );
endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
  import errcap_pkg::*;
#(
  parameter int CAPW = 54
) (
  input logic            clk,
  input logic            rst_n,
  input cls_vec_t        evt_gated,
  input cls_vec_t        status_q,
  input cls_vec_t        lost_q,
  input cls_vec_t        mask_q,
  input logic            valid_q,
  input logic            cap_fire,
  input logic            status_wr,
  input logic            apar_en,
  input logic            dpar_en,
  input logic [CAPW-1:0] cap_bus,
  input logic            err_irq,
  input logic            err_mchk
);
  for (genvar i = 0; i < NCLS; i++) begin : g_cls
    // R1
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_gated[i] |=> status_q[i]);
    // R4
    lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_q[i]) |-> $past(evt_gated[i]) && $past(status_q[i]));
  end

  // R4
  serr_nolost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lost_q[C_SERR]);

  // R1
  valid_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_q) |-> valid_q);

  // R3
  capture_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !status_wr) |=> $stable(cap_bus));

  // R2
  capture_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_bus) |-> $past(cap_fire));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[C_CORR] |-> !err_irq);

  // R7
  mchk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & mask_q & UNC_GRP) == '0) |-> !err_mchk);

  // R8
  apar_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[C_APAR]) |-> $past(apar_en));

  // R8
  dpar_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[C_DPAR]) |-> $past(dpar_en));
endmodule

bind errcap_top errcap_chk #(.CAPW(CAPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_gated(evt_gated), .status_q(status_q),
  .lost_q(lost_q), .mask_q(mask_q), .valid_q(valid_q), .cap_fire(cap_fire),
  .status_wr(status_wr), .apar_en(apar_en), .dpar_en(dpar_en),
  .cap_bus(cap_bus), .err_irq(err_irq), .err_mchk(err_mchk)
);

// File: tb/errcap_top_tb.sv
module errcap_top_tb;
  localparam int AW = 35;
  localparam int CW = 4;
  localparam int SW = 8;
  localparam int WW = 2;
  localparam logic [31:0] VALID = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [11:0]   evt_pulse = '0;
  logic [AW-1:4] evt_line = '0;
  logic [CW-1:0] evt_cmd = '0;
  logic [SW-1:0] evt_syn = '0;
  logic [WW-1:0] evt_win = '0;
  logic          evt_dma = 1'b0;
  logic          err_irq, err_mchk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  errcap_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .evt_line(evt_line), .evt_cmd(evt_cmd), .evt_syn(evt_syn),
    .evt_win(evt_win), .evt_dma(evt_dma), .err_irq(err_irq), .err_mchk(err_mchk)
  );

  task automatic expect_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    expect_eq(req, reg_rdata, exp);
  endtask

  task automatic pulse(logic [11:0] v, logic [AW-1:0] adr, logic [CW-1:0] c,
                       logic [SW-1:0] s, logic [WW-1:0] w, logic d);
    @(negedge clk);
    evt_pulse = v; evt_line = adr[AW-1:4]; evt_cmd = c; evt_syn = s;
    evt_win = w; evt_dma = d;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  function automatic logic [31:0] hi_word(logic [AW-1:0] adr, logic [CW-1:0] c, logic d);
    return {15'd0, d, 4'd0, 4'(c), 5'd0, adr[34:32]};
  endfunction

  function automatic logic [31:0] syn_word(logic [SW-1:0] s, logic [WW-1:0] w, int cls);
    return {16'd0, 4'(cls), 2'd0, w, s};
  endfunction

  task automatic clear_all();
    wr(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd_chk("R10 status", 3'd0, 32'h0);
    rd_chk("R10 mask", 3'd1, 32'h0);
    rd_chk("R10 ctrl", 3'd2, 32'h3);
    expect_eq("R10 irq", {31'd0, err_irq}, 32'd0);
    expect_eq("R10 mchk", {31'd0, err_mchk}, 32'd0);
  endtask

  localparam logic [AW-1:0] A1 = 35'h5_1234_567B;

  task automatic t_first_capture();
    wr(3'd1, 32'hFFF);
    pulse(12'h002, A1, 4'hA, 8'h3C, 2'd2, 1'b1);
    rd_chk("R1 status uncorr", 3'd0, VALID | 32'h2);
    rd_chk("R2 addr low", 3'd3, 32'h1234_5670);
    rd_chk("R9 addr high no dma for uncorr", 3'd4, hi_word(A1, 4'hA, 1'b0));
    rd_chk("R2 syndrome word", 3'd5, syn_word(8'h3C, 2'd2, 1));
    expect_eq("R7 mchk raised", {31'd0, err_mchk}, 32'd1);
    expect_eq("R7 irq low", {31'd0, err_irq}, 32'd0);
  endtask

  task automatic t_lost_same();
    pulse(12'h002, 35'h0_0000_0100, 4'h1, 8'h77, 2'd1, 1'b0);
    rd_chk("R4 lost uncorr", 3'd0, VALID | 32'h2 | (32'h1 << 17));
    rd_chk("R3 addr locked", 3'd3, 32'h1234_5670);
    rd_chk("R3 syn locked", 3'd5, syn_word(8'h3C, 2'd2, 1));
  endtask

  task automatic t_other_locked();
    pulse(12'h100, 35'h3_0000_0000, 4'h2, 8'h55, 2'd3, 1'b0);
    rd_chk("R3 other class status", 3'd0, VALID | 32'h102 | (32'h1 << 17));
    rd_chk("R3 high locked", 3'd4, hi_word(A1, 4'hA, 1'b0));
  endtask

  task automatic t_write_zero();
    wr(3'd0, 32'h0);
    rd_chk("R5 write zero", 3'd0, VALID | 32'h102 | (32'h1 << 17));
  endtask

  task automatic t_partial();
    wr(3'd0, VALID | 32'h100 | (32'h1 << 17));
    rd_chk("R5 partial keeps valid", 3'd0, VALID | 32'h2);
    pulse(12'h004, 35'h1_0000_0010, 4'h3, 8'h01, 2'd0, 1'b0);
    rd_chk("R3 still locked", 3'd5, syn_word(8'h3C, 2'd2, 1));
    rd_chk("R5 status after", 3'd0, VALID | 32'h6);
    clear_all();
    rd_chk("R5 full clear", 3'd0, 32'h0);
    expect_eq("R7 mchk drops", {31'd0, err_mchk}, 32'd0);
  endtask

  localparam logic [AW-1:0] A2 = 35'h2_0000_0040;

  task automatic t_priority();
    pulse(12'h089, A2, 4'h3, 8'h11, 2'd1, 1'b1);
    rd_chk("R6 all bits set", 3'd0, VALID | 32'h089);
    rd_chk("R6 nxm wins", 3'd5, syn_word(8'h11, 2'd1, 3));
    rd_chk("R9 dma source", 3'd4, hi_word(A2, 4'h3, 1'b1));
    rd_chk("R3 unlocked recapture addr", 3'd3, 32'h0000_0040);
    expect_eq("R7 irq level", {31'd0, err_irq}, 32'd1);
    clear_all();
    pulse(12'h081, A2, 4'h3, 8'h22, 2'd0, 1'b0);
    rd_chk("R6 pci beats correctable", 3'd5, syn_word(8'h22, 2'd0, 7));
    clear_all();
    pulse(12'h001, A2, 4'h3, 8'h44, 2'd0, 1'b0);
    rd_chk("R6 correctable alone", 3'd5, syn_word(8'h44, 2'd0, 0));
    clear_all();
  endtask

  localparam logic [AW-1:0] A3 = 35'h7_FFFF_FFF0;

  task automatic t_nxm_cpu();
    pulse(12'h008, A3, 4'hF, 8'h00, 2'd3, 1'b0);
    rd_chk("R9 cpu source", 3'd4, hi_word(A3, 4'hF, 1'b0));
    rd_chk("R2 top address", 3'd3, 32'hFFFF_FFF0);
    clear_all();
  endtask

  task automatic t_ctrl_gate();
    wr(3'd2, 32'h0);
    rd_chk("R8 ctrl cleared", 3'd2, 32'h0);
    pulse(12'h060, A1, 4'h1, 8'h01, 2'd1, 1'b0);
    rd_chk("R8 parity ignored", 3'd0, 32'h0);
    expect_eq("R8 no mchk", {31'd0, err_mchk}, 32'd0);
    wr(3'd2, 32'h1);
    pulse(12'h060, A1, 4'h1, 8'h01, 2'd1, 1'b0);
    rd_chk("R8 addr parity only", 3'd0, VALID | 32'h040);
    clear_all();
    wr(3'd2, 32'h3);
  endtask

  task automatic t_serr_lost();
    pulse(12'h010, A1, 4'h1, 8'h01, 2'd1, 1'b0);
    pulse(12'h010, A1, 4'h1, 8'h01, 2'd1, 1'b0);
    rd_chk("R4 serr no lost", 3'd0, VALID | 32'h010);
    clear_all();
  endtask

  task automatic t_mask();
    wr(3'd1, 32'h001);
    pulse(12'h001, A1, 4'h1, 8'h01, 2'd1, 1'b0);
    expect_eq("R7 irq on", {31'd0, err_irq}, 32'd1);
    pulse(12'h200, A1, 4'h1, 8'h01, 2'd1, 1'b0);
    expect_eq("R7 masked mchk", {31'd0, err_mchk}, 32'd0);
    wr(3'd1, 32'h201);
    expect_eq("R7 unmask mchk", {31'd0, err_mchk}, 32'd1);
    wr(3'd1, 32'h000);
    rd_chk("R7 mask readback", 3'd1, 32'h0);
    expect_eq("R7 irq off", {31'd0, err_irq}, 32'd0);
    expect_eq("R7 mchk off", {31'd0, err_mchk}, 32'd0);
    clear_all();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_capture();
    t_lost_same();
    t_other_locked();
    t_write_zero();
    t_partial();
    t_priority();
    t_nxm_cpu();
    t_ctrl_gate();
    t_serr_lost();
    t_mask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule